// File: doc/BRIEF.md
# Host-Kick Watchdog with Configuration Register Restore

This block holds one 8-bit configuration register for a power-management controller and runs a host watchdog on it. The host writes the whole register with a single write strobe, and the current contents appear on a read-data port. A one-second tick input drives a counter toward a timeout that the register's own 2-bit timeout field selects. If the host stays silent for the whole selected period, every field of the register goes back to its default and an expiry output pulses for one clock.

The host keeps the watchdog alive in either of two ways. It can write the register with the kick bit set; the kick bit then clears itself. It can also write a new value into the timeout field. A write that leaves the timeout field unchanged and has the kick bit clear does not restart the count. A synchronous software-reset input restores the defaults and clears the count. The tick is a port so that a bench can compress time.

Top module: `hostwd_cfg_reg`

## Requirements
- R1: After reset, read data is 0x9D: termination enable (bit 7) = 1, kick (bit 6) = 0, timeout (bits 5:4) = 1, safety-timer enable (bit 3) = 1, safety-timer select (bits 2:1) = 2, half-rate enable (bit 0) = 1.
- R2: A write stores all eight bits at the positions given in R1, and they appear on read data from the clock edge that samples the write strobe.
- R3: Timeout code 1 selects 40 ticks, code 2 selects 80 ticks and code 3 selects 160 ticks, counted from the most recent restart.
- R4: Expiry happens on the edge that samples the Nth tick after a restart, where N is the selected period. The expiry output is then high for exactly one clock cycle.
- R5: On expiry the register returns to 0x9D at that same edge, and the count restarts from zero with the 40-tick default period.
- R6: A write with bit 6 set restarts the count. Bit 6 reads 1 for the cycle after the write and reads 0 after the next edge that samples no write.
- R7: A write that changes bits 5:4 restarts the count. A write that leaves bits 5:4 unchanged and has bit 6 clear does not restart it.
- R8: While the timeout field is 0, the count is held at zero and no expiry ever occurs.
- R9: A software-reset pulse restores 0x9D, clears the count and suppresses any expiry in that cycle.
- R10: If a restarting write and the expiring tick arrive in the same cycle, the write wins and no expiry occurs. If a non-restarting write and the expiring tick arrive in the same cycle, the expiry wins and the register holds 0x9D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_rst_i | input | 1 | Synchronous software reset to defaults |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Current register contents |
| expire_o | output | 1 | One-cycle watchdog expiry pulse |

## Verification
All 256 write values are swept through the register, and each is read back on the cycle after the write and again one idle cycle later. This separates the stored field positions from the self-clearing kick bit. For each nonzero timeout code, tick trains are run that stop one tick short of the period and then reach it, so an off-by-one limit and a wrong period are caught. Further tick trains, interrupted by a kick, by a same-value write, by a changing write, by a software reset, or by a write that lands on the expiring tick, show which events restart the count and which priority holds when events collide.

// File: rtl/hostwd_pkg.sv
package hostwd_pkg;

    typedef struct packed {
        logic       term_en;
        logic       kick;
        logic [1:0] wd_sel;
        logic       safe_en;
        logic [1:0] safe_sel;
        logic       half_en;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{
        term_en:  1'b1,
        kick:     1'b0,
        wd_sel:   2'd1,
        safe_en:  1'b1,
        safe_sel: 2'd2,
        half_en:  1'b1
    };

    localparam logic [1:0] WD_OFF = 2'd0;

    function automatic logic wd_enabled(input logic [1:0] sel);
        return sel != WD_OFF;
    endfunction

endpackage

// File: rtl/hostwd_regfile.sv
module hostwd_regfile
    import hostwd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_dflt_i,
    input  logic wr_en_i,
    input  cfg_t wr_data_i,
    output cfg_t cfg_o
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst || load_dflt_i) begin
            cfg_q <= CFG_DEFAULT;
        end else if (wr_en_i) begin
            cfg_q <= wr_data_i;
        end else begin
            cfg_q.kick <= 1'b0;
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/hostwd_restart_det.sv
module hostwd_restart_det
    import hostwd_pkg::*;
(
    input  logic       wr_en_i,
    input  cfg_t       wr_data_i,
    input  logic [1:0] cur_sel_i,
    input  logic       sw_rst_i,
    output logic       clear_o
);
    logic kick_wr;
    logic sel_change;

    always_comb begin
        kick_wr    = wr_en_i && wr_data_i.kick;
        sel_change = wr_en_i && (wr_data_i.wd_sel != cur_sel_i);
        clear_o    = kick_wr || sel_change || sw_rst_i;
    end
endmodule

// File: rtl/hostwd_timer.sv
module hostwd_timer
    import hostwd_pkg::*;
#(
    parameter int unsigned BASE_TICKS = 40,
    parameter int unsigned CNT_W      = $clog2(BASE_TICKS * 4 + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [1:0]       sel_i,
    input  logic             clear_i,
    output logic             expire_now_o,
    output logic             expire_q_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] LIM_1 = CNT_W'(BASE_TICKS);
    localparam logic [CNT_W-1:0] LIM_2 = CNT_W'(BASE_TICKS * 2);
    localparam logic [CNT_W-1:0] LIM_3 = CNT_W'(BASE_TICKS * 4);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             hit;
    logic             expire_q;

    always_comb begin
        unique case (sel_i)
            2'd1:    limit = LIM_1;
            2'd2:    limit = LIM_2;
            2'd3:    limit = LIM_3;
            default: limit = '0;
        endcase
        hit          = tick_i && wd_enabled(sel_i) && (cnt_q == limit - 1'b1);
        expire_now_o = hit && !clear_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clear_i || !wd_enabled(sel_i) || expire_now_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) expire_q <= 1'b0;
        else     expire_q <= expire_now_o;
    end

    assign expire_q_o = expire_q;
    assign count_o    = cnt_q;
endmodule

// File: rtl/hostwd_cfg_reg.sv
module hostwd_cfg_reg
    import hostwd_pkg::*;
#(
    parameter int unsigned BASE_TICKS = 40,
    localparam int unsigned CNT_W     = $clog2(BASE_TICKS * 4 + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sw_rst_i,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o,
    output logic       expire_o
);
    cfg_t             wr_cfg;
    cfg_t             cfg;
    logic             clear;
    logic             expire_now;
    logic [CNT_W-1:0] wd_count;

    assign wr_cfg = cfg_t'(wr_data_i);

    hostwd_restart_det u_restart (
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_cfg),
        .cur_sel_i (cfg.wd_sel),
        .sw_rst_i  (sw_rst_i),
        .clear_o   (clear)
    );

    hostwd_timer #(
        .BASE_TICKS (BASE_TICKS),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i),
        .sel_i        (cfg.wd_sel),
        .clear_i      (clear),
        .expire_now_o (expire_now),
        .expire_q_o   (expire_o),
        .count_o      (wd_count)
    );

    hostwd_regfile u_regs (
        .clk         (clk),
        .rst         (rst),
        .load_dflt_i (sw_rst_i || expire_now),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_cfg),
        .cfg_o       (cfg)
    );

    assign rd_data_o = cfg;
endmodule

// File: rtl/hostwd_checker.sv
module hostwd_checker
    import hostwd_pkg::*;
#(
    parameter int unsigned BASE_TICKS = 40,
    parameter int unsigned CNT_W      = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             sw_rst_i,
    input logic             wr_en_i,
    input logic [7:0]       rd_data_o,
    input logic             expire_o,
    input logic [CNT_W-1:0] wd_count
);
    logic [CNT_W-1:0] lim;
    logic             cnt_ok;

    always_comb begin
        case (rd_data_o[5:4])
            2'd1:    lim = CNT_W'(BASE_TICKS);
            2'd2:    lim = CNT_W'(BASE_TICKS * 2);
            2'd3:    lim = CNT_W'(BASE_TICKS * 4);
            default: lim = '0;
        endcase
        cnt_ok = (rd_data_o[5:4] == 2'd0) ? (wd_count == '0) : (wd_count < lim);
    end

    AST_EXPIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> !expire_o);                                   // R4
    AST_EXPIRE_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        expire_o |-> (rd_data_o == 8'h9D) && (wd_count == '0));    // R5
    AST_KICK_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> !rd_data_o[6]);                               // R6
    AST_OFF_NO_EXPIRE: assert property (@(posedge clk) disable iff (rst)
        (rd_data_o[5:4] == 2'd0) && !wr_en_i |=> !expire_o);       // R8
    AST_SWRST_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        sw_rst_i |=> (rd_data_o == 8'h9D) && !expire_o && (wd_count == '0)); // R9
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_ok);                                                   // R3
endmodule

bind hostwd_cfg_reg hostwd_checker #(
    .BASE_TICKS (BASE_TICKS),
    .CNT_W      (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sw_rst_i  (sw_rst_i),
    .wr_en_i   (wr_en_i),
    .rd_data_o (rd_data_o),
    .expire_o  (expire_o),
    .wd_count  (wd_count)
);

// File: tb/hostwd_cfg_reg_tb.sv
`timescale 1ns/1ps
module hostwd_cfg_reg_tb_top;
    localparam int BASE = 40;
    localparam logic [7:0] DFLT = 8'h9D;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sw_rst = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       expire;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hostwd_cfg_reg #(.BASE_TICKS(BASE)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .sw_rst_i  (sw_rst),
        .tick_i    (tick),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .expire_o  (expire)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // n tick pulses; reports first tick index that expired and expiry count
    task automatic run_ticks(input int n, output int first, output int cnt);
        first = 0; cnt = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            if (expire) begin
                cnt++;
                if (first == 0) first = i;
            end
        end
    endtask

    function automatic int period(input int sel);
        return (sel == 0) ? 0 : BASE * (1 << (sel - 1));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog timeout actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int first, cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset value", rd_data, DFLT);
        check("R1 no expiry after reset", expire, 0);

        // R2 / R6: full write sweep, kick bit self-clears
        for (int d = 0; d < 256; d++) begin
            write_reg(8'(d));
            check("R2 readback", rd_data, d);
            @(negedge clk);
            check("R6 kick self-clear", rd_data, d & 8'hBF);
        end

        // R3 / R4 / R5: each period, stop one short then reach it
        for (int sel = 1; sel <= 3; sel++) begin
            write_reg(8'h40 | 8'(sel << 4));
            run_ticks(period(sel) - 1, first, cnt);
            check("R3 no expiry before period", cnt, 0);
            run_ticks(1, first, cnt);
            check("R4 expiry on Nth tick", cnt, 1);
            check("R5 defaults on expiry", rd_data, DFLT);
            @(negedge clk);
            check("R4 single-cycle pulse", expire, 0);
            run_ticks(BASE, first, cnt);
            check("R5 restart with default period", first, BASE);
        end

        // R7: same-value write does not restart
        write_reg(8'h60);
        run_ticks(50, first, cnt);
        write_reg(8'h20);
        run_ticks(40, first, cnt);
        check("R7 same value keeps count", first, 30);

        // R7: changing write restarts
        run_ticks(20, first, cnt);
        write_reg(8'h20);
        run_ticks(80, first, cnt);
        check("R7 changed field restarts", first, 80);

        // R6: kick restarts
        run_ticks(30, first, cnt);
        write_reg(8'h50);
        run_ticks(40, first, cnt);
        check("R6 kick restarts count", first, 40);

        // R8: disabled
        write_reg(8'h0A);
        run_ticks(200, first, cnt);
        check("R8 disabled never expires", cnt, 0);
        check("R8 register kept", rd_data, 8'h0A);

        // R9: software reset
        write_reg(8'h7E);
        run_ticks(100, first, cnt);
        @(negedge clk); sw_rst = 1'b1;
        @(negedge clk); sw_rst = 1'b0;
        check("R9 defaults after sw reset", rd_data, DFLT);
        run_ticks(40, first, cnt);
        check("R9 count cleared", first, 40);

        // R9: sw reset on expiring tick suppresses expiry
        run_ticks(39, first, cnt);
        @(negedge clk); sw_rst = 1'b1; tick = 1'b1;
        @(negedge clk); sw_rst = 1'b0; tick = 1'b0;
        check("R9 sw reset suppresses expiry", expire, 0);

        // R10: restarting write collides with expiring tick
        run_ticks(39, first, cnt);
        @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_data = 8'h52;
        @(negedge clk); tick = 1'b0; wr_en = 1'b0;
        check("R10 kick beats expiry", expire, 0);
        check("R10 write stored", rd_data, 8'h52);
        run_ticks(40, first, cnt);
        check("R10 count restarted", first, 40);

        // R10: non-restarting write collides with expiring tick
        run_ticks(39, first, cnt);
        @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_data = 8'h10;
        @(negedge clk); tick = 1'b0; wr_en = 1'b0;
        check("R10 expiry beats plain write", expire, 1);
        check("R10 defaults win", rd_data, DFLT);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule